// File: doc/BRIEF.md
# Four-Level Address Translation Walker

The walker turns a 64-bit virtual address into a 52-bit physical address by reading up to four levels of translation tables held in memory. Each table is one 4 KB page of 512 eight-byte entries. The first table is found through a root base input. Each later table, or the final page, is named by the frame field of the entry read one level above. A walk can end early on a large-page entry and produce a 1 GB or 2 MB mapping. It stops at once on an entry whose present bit is clear. A virtual address whose upper bits are not a sign extension is refused without touching memory.

A request enters through a valid/ready handshake. `req_ready` is high only while the walker is idle, so the requester must hold `req_valid` and its payload until it sees `req_ready`. Table reads leave through a request port with its own valid/ready pair. The walker holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen, and keeps exactly one read in flight. The response port has no back-pressure: the walker takes `mem_rsp_data` in any cycle where `mem_rsp_valid` is high while it waits. The result appears with a one-cycle `done` pulse and is held until the next result.

Levels are numbered 3 (root table) down to 0 (last table). The fault cause codes are: 0 none, 1 entry not present, 2 non-canonical address, 3 access not permitted.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. It is high after reset and drops in the cycle after a request is accepted. `done` and `mem_req_valid` are low after reset.
- R2: If bits 63:47 of the request address are not all equal, the walker issues no memory read. `done` rises in the first cycle after acceptance with fault=1, cause 2 and level 3.
- R3: The first read goes to the root base. Each read address is the table base plus 8 times the 9-bit index for that level. The index is taken from virtual bits 47:39, 38:30, 29:21 or 20:12 for levels 3, 2, 1 and 0.
- R4: A memory request keeps its valid and address stable until it is accepted. Only one read is outstanding at a time.
- R5: An entry with bit 0 clear ends the walk with cause 1 and the level at which it was read. No further read follows.
- R6: When level 0 is reached, the result is entry bits 51:12 joined with virtual bits 11:0. This takes four reads.
- R7: An entry read at level 2 with bit 7 set is a 1 GB leaf. The result is entry bits 51:30 with virtual bits 29:0, after two reads.
- R8: An entry read at level 1 with bit 7 set is a 2 MB leaf. The result is entry bits 51:21 with virtual bits 20:0, after three reads. Bit 7 of a level-3 entry is ignored.
- R9: The reported write grant is the AND of bit 1 over all entries read. The user grant is the AND of bit 2. No-execute is the OR of bit 63.
- R10: A request that asks for write without the write grant, for user access without the user grant, or for execute with no-execute set ends with cause 3 at the leaf level.
- R11: `done` is high for one cycle only. A fault reports a physical address of 0. The result outputs hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted on this cycle if valid |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access needs write permission |
| req_user | input | 1 | Access is from user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| root_base | input | 52 | Physical base of the level-3 table |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle result strobe |
| res_paddr | output | 52 | Translated physical address, 0 on fault |
| res_write | output | 1 | Combined write grant |
| res_user | output | 1 | Combined user grant |
| res_nx | output | 1 | Combined no-execute |
| res_fault | output | 1 | Translation failed |
| res_level | output | 2 | Level where the walk stopped |
| res_cause | output | 2 | Fault cause code |

## Verification
A non-canonical request must raise `done` in the very first cycle after acceptance. The bench samples on falling edges and checks that timing exactly. A walk finishes one cycle after its last response is accepted, and that moment depends on the random ready and latency of the bench memory. For walks the bench therefore polls `done` on each falling edge with a bound, and checks that it is low again one edge later with the result still held. While waiting, every falling edge also confirms that `req_ready` stays low. The read addresses seen by the memory model are compared in order with those of an independent reference walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_ABSENT   = 2'd1,
    CAUSE_NONCANON = 2'd2,
    CAUSE_PERM     = 2'd3
  } fault_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;

  localparam int unsigned ENTRY_W     = 64;
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;
  localparam int unsigned BIT_LARGE   = 7;
  localparam int unsigned BIT_NOEXEC  = 63;
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int VA_W   = 48,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] index
);
  logic [IDX_W-1:0] idx_tab [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    assign idx_tab[l] = vaddr[OFF_W + l*IDX_W +: IDX_W];
  end

  assign index = idx_tab[level];
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walk_pkg::*;
#(
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int FRM_W = PA_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [LVL_W-1:0]   level,
  input  logic [PA_W-1:0]    va_low,
  output logic               present,
  output logic               is_leaf,
  output logic               grant_w,
  output logic               grant_u,
  output logic               no_exec,
  output logic [FRM_W-1:0]   frame,
  output logic [PA_W-1:0]    leaf_pa
);
  logic        large_ok;
  logic [PA_W-1:0] keep_mask;
  int unsigned off_bits;

  assign present  = entry[BIT_PRESENT];
  assign grant_w  = entry[BIT_WRITE];
  assign grant_u  = entry[BIT_USER];
  assign no_exec  = entry[BIT_NOEXEC];
  assign frame    = entry[PA_W-1:OFF_W];
  assign large_ok = (level != '0) && (level != LVL_W'(LEVELS-1));
  assign is_leaf  = (level == '0) || (entry[BIT_LARGE] && large_ok);

  always_comb begin
    off_bits  = OFF_W + int'(level) * IDX_W;
    keep_mask = (PA_W'(1) << off_bits) - PA_W'(1);
    leaf_pa   = ({frame, {OFF_W{1'b0}}} & ~keep_mask) | (va_low & keep_mask);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [63:0]                req_vaddr,
  input  logic                       req_write,
  input  logic                       req_user,
  input  logic                       req_exec,
  input  logic [PA_W-1:0]            root_base,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [PA_W-1:0]            mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [63:0]                mem_rsp_data,
  output logic                       done,
  output logic [PA_W-1:0]            res_paddr,
  output logic                       res_write,
  output logic                       res_user,
  output logic                       res_nx,
  output logic                       res_fault,
  output logic [$clog2(LEVELS)-1:0]  res_level,
  output logic [1:0]                 res_cause
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int FRM_W  = PA_W - OFF_W;
  localparam int SIGN_W = 64 - VA_W + 1;

  walk_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic [FRM_W-1:0] base_q;
  logic [VA_W-1:0]  va_q;
  logic             want_w_q, want_u_q, want_x_q;
  logic             acc_w_q, acc_u_q, acc_nx_q;

  logic [SIGN_W-1:0] sign_bits;
  logic              canon;
  logic [IDX_W-1:0]  index;
  logic              e_present, e_leaf, e_w, e_u, e_nx;
  logic [FRM_W-1:0]  e_frame;
  logic [PA_W-1:0]   e_leaf_pa;
  logic              nw, nu, nnx, denied;

  assign sign_bits = req_vaddr[63:VA_W-1];
  assign canon     = (&sign_bits) | ~(|sign_bits);

  pt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_split (
    .vaddr (va_q),
    .level (level_q),
    .index (index)
  );

  pt_pte_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_dec (
    .entry   (mem_rsp_data),
    .level   (level_q),
    .va_low  (PA_W'(va_q)),
    .present (e_present),
    .is_leaf (e_leaf),
    .grant_w (e_w),
    .grant_u (e_u),
    .no_exec (e_nx),
    .frame   (e_frame),
    .leaf_pa (e_leaf_pa)
  );

  assign nw     = acc_w_q & e_w;
  assign nu     = acc_u_q & e_u;
  assign nnx    = acc_nx_q | e_nx;
  assign denied = (want_w_q & ~nw) | (want_u_q & ~nu) | (want_x_q & nnx);

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = (state_q == ST_DONE);
  assign mem_req_addr  = {base_q, {OFF_W{1'b0}}} + (PA_W'(index) << 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      level_q   <= '0;
      base_q    <= '0;
      va_q      <= '0;
      want_w_q  <= 1'b0;
      want_u_q  <= 1'b0;
      want_x_q  <= 1'b0;
      acc_w_q   <= 1'b0;
      acc_u_q   <= 1'b0;
      acc_nx_q  <= 1'b0;
      res_paddr <= '0;
      res_write <= 1'b0;
      res_user  <= 1'b0;
      res_nx    <= 1'b0;
      res_fault <= 1'b0;
      res_level <= '0;
      res_cause <= CAUSE_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q     <= req_vaddr[VA_W-1:0];
          want_w_q <= req_write;
          want_u_q <= req_user;
          want_x_q <= req_exec;
          acc_w_q  <= 1'b1;
          acc_u_q  <= 1'b1;
          acc_nx_q <= 1'b0;
          level_q  <= LVL_W'(LEVELS-1);
          base_q   <= root_base[PA_W-1:OFF_W];
          if (!canon) begin
            res_paddr <= '0;
            res_write <= 1'b0;
            res_user  <= 1'b0;
            res_nx    <= 1'b0;
            res_fault <= 1'b1;
            res_level <= LVL_W'(LEVELS-1);
            res_cause <= CAUSE_NONCANON;
            state_q   <= ST_DONE;
          end else begin
            state_q   <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!e_present) begin
            res_paddr <= '0;
            res_write <= 1'b0;
            res_user  <= 1'b0;
            res_nx    <= 1'b0;
            res_fault <= 1'b1;
            res_level <= level_q;
            res_cause <= CAUSE_ABSENT;
            state_q   <= ST_DONE;
          end else if (e_leaf) begin
            res_paddr <= denied ? '0 : e_leaf_pa;
            res_write <= nw;
            res_user  <= nu;
            res_nx    <= nnx;
            res_fault <= denied;
            res_level <= level_q;
            res_cause <= denied ? CAUSE_PERM : CAUSE_NONE;
            state_q   <= ST_DONE;
          end else begin
            acc_w_q  <= nw;
            acc_u_q  <= nu;
            acc_nx_q <= nnx;
            base_q   <= e_frame;
            level_q  <= level_q - 1'b1;
            state_q  <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [63:0]               req_vaddr,
  input logic                      mem_req_valid,
  input logic                      mem_req_ready,
  input logic [PA_W-1:0]           mem_req_addr,
  input logic                      mem_rsp_valid,
  input logic [63:0]               mem_rsp_data,
  input logic                      done,
  input logic [PA_W-1:0]           res_paddr,
  input logic                      res_fault,
  input logic [$clog2(LEVELS)-1:0] res_level,
  input logic [1:0]                res_cause
);
  logic [64-VA_W:0] upper;
  logic             is_canon;
  logic             waiting;

  assign upper    = req_vaddr[63:VA_W-1];
  assign is_canon = (&upper) | ~(|upper);
  assign waiting  = !req_ready && !mem_req_valid && !done;

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> !req_ready);

  assert_noncanon_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !is_canon) |=> (done && res_fault && res_cause == 2'd2 && !mem_req_valid));

  assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && mem_rsp_valid && !mem_rsp_data[0]) |=> (done && res_fault && res_cause == 2'd1));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_fault) |-> (res_paddr == '0 && res_cause != 2'd0));

  assert_clean_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_fault) |-> (res_cause == 2'd0));

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$rose(done) && $past(!done)) |-> ($stable(res_paddr) && $stable(res_level)));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
  logic [51:0] root_base = 52'h1000;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [51:0] res_paddr;
  logic        res_write, res_user, res_nx, res_fault;
  logic [1:0]  res_level, res_cause;

  int checks = 0;
  int errors = 0;

  logic [63:0] pmem [logic [51:0]];
  logic [51:0] rd_addr [$];

  logic [51:0] e_pa;
  logic        e_w, e_u, e_nx, e_f;
  logic [1:0]  e_c, e_l;
  int          e_n;
  logic [51:0] e_addr [4];

  always #2.5 clk = ~clk;

  pt_walker u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write, .req_user, .req_exec,
    .root_base, .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .done, .res_paddr, .res_write, .res_user, .res_nx, .res_fault, .res_level, .res_cause
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_entry(input logic [51:0] a);
    return pmem.exists(a) ? pmem[a] : 64'd0;
  endfunction

  // Reference walk built from the requirements
  function automatic void ref_walk(input logic [63:0] va, input bit w, input bit u, input bit x);
    logic [16:0] up;
    logic [51:0] base, a, mask;
    logic [63:0] e;
    logic [8:0]  idx;
    bit aw, au, anx;
    e_pa = '0; e_w = 0; e_u = 0; e_nx = 0; e_f = 0; e_c = 0; e_l = 0; e_n = 0;
    up = va[63:47];
    if (!(&up) && (|up)) begin
      e_f = 1; e_c = 2; e_l = 3;
      return;
    end
    base = root_base; aw = 1; au = 1; anx = 0;
    for (int l = 3; l >= 0; l--) begin
      idx = va[12 + 9*l +: 9];
      a = base + {40'd0, idx, 3'b000};
      e_addr[e_n] = a; e_n++;
      e = rd_entry(a);
      if (!e[0]) begin e_f = 1; e_c = 1; e_l = 2'(l); return; end
      aw &= e[1]; au &= e[2]; anx |= e[63];
      if (l == 0 || (e[7] && l < 3)) begin
        mask = (52'd1 << (12 + 9*l)) - 52'd1;
        e_pa = ({e[51:12], 12'd0} & ~mask) | (va[51:0] & mask);
        e_w = aw; e_u = au; e_nx = anx; e_l = 2'(l);
        if ((w && !aw) || (u && !au) || (x && anx)) begin
          e_f = 1; e_c = 3; e_pa = '0;
        end
        return;
      end
      base = {e[51:12], 12'd0};
    end
  endfunction

  // Memory model: random accept and latency
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        automatic logic [51:0] a = mem_req_addr;
        automatic int lat = $urandom % 3;
        rd_addr.push_back(a);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd_entry(a);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
      end
    end
  end

  task automatic run_req(input logic [63:0] va, input bit w, input bit u, input bit x, input string tag);
    int cyc;
    bit busy_bad;
    ref_walk(va, w, u, x);
    rd_addr.delete();
    @(negedge clk);
    check(req_ready === 1'b1, "R1", "idle ready", req_ready, 1);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; req_exec = x;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; busy_bad = 0;
    while (done !== 1'b1 && cyc < 200) begin
      if (req_ready !== 1'b0) busy_bad = 1;
      @(negedge clk);
      cyc++;
    end
    check(!busy_bad, "R1", "ready low while busy", busy_bad, 0);
    check(done === 1'b1, tag, "done seen", done, 1);
    if (e_c == 2) check(cyc == 1, "R2", "noncanonical latency", cyc, 1);
    check(res_fault === e_f, tag, "fault", res_fault, e_f);
    check(res_cause === e_c, tag, "cause", res_cause, e_c);
    check(res_paddr === e_pa, tag, "paddr", res_paddr, e_pa);
    if (e_f) check(res_level === e_l, tag, "level", res_level, e_l);
    if (e_c == 0 || e_c == 3)
      check({res_write, res_user, res_nx} === {e_w, e_u, e_nx}, "R9", "perms",
            {res_write, res_user, res_nx}, {e_w, e_u, e_nx});
    check(rd_addr.size() == e_n, "R3", "read count", rd_addr.size(), e_n);
    for (int i = 0; i < e_n && i < rd_addr.size(); i++)
      check(rd_addr[i] === e_addr[i], "R3", "read address", rd_addr[i], e_addr[i]);
    @(negedge clk);
    check(done === 1'b0, "R11", "done one cycle", done, 0);
    check(res_paddr === e_pa, "R11", "result held", res_paddr, e_pa);
  endtask

  // Directed chain: pointers to distinct frames, leaf at leaf_l, absent at hole_l
  task automatic build_chain(input logic [63:0] va, input int leaf_l, input int hole_l,
                             input logic [51:0] leaf_pa, input int ro_l, input bit top_large);
    logic [51:0] base = root_base;
    for (int l = 3; l >= 0; l--) begin
      automatic logic [51:0] a = base + {40'd0, va[12 + 9*l +: 9], 3'b000};
      automatic logic [63:0] e = 64'h7;
      if (l == ro_l) begin e[1] = 1'b0; e[63] = 1'b1; end
      if (l == 3 && top_large) e[7] = 1'b1;
      if (l == hole_l) begin pmem[a] = 64'd0; return; end
      if (l == leaf_l) begin
        e[51:12] = leaf_pa[51:12];
        if (l > 0) e[7] = 1'b1;
        pmem[a] = e;
        return;
      end
      e[51:12] = 40'(32 + (3 - l));
      pmem[a] = e;
      base = {e[51:12], 12'd0};
    end
  endtask

  task automatic populate(input logic [63:0] va);
    logic [51:0] base = root_base;
    for (int l = 3; l >= 0; l--) begin
      automatic logic [51:0] a = base + {40'd0, va[12 + 9*l +: 9], 3'b000};
      automatic bit p  = ($urandom % 16) != 0;
      automatic bit ps = (l == 1 || l == 2) ? (($urandom % 4) == 0) : (($urandom % 8) == 0);
      automatic logic [39:0] fr = (($urandom % 4) == 0) ? {$urandom, $urandom} : 40'(2 + $urandom % 60);
      automatic logic [63:0] e = {(($urandom % 5) == 0) ? 1'b1 : 1'b0, 11'd0, fr, 4'd0, ps, 4'd0,
                                  (($urandom % 4) != 0) ? 1'b1 : 1'b0,
                                  (($urandom % 4) != 0) ? 1'b1 : 1'b0, p};
      pmem[a] = e;
      if (!p || l == 0 || (ps && l < 3)) return;
      base = {fr, 12'd0};
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1", "reset ready", req_ready, 1);
    check(done === 1'b0, "R1", "reset done", done, 0);
    check(mem_req_valid === 1'b0, "R1", "reset mem valid", mem_req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    build_chain(64'h0000_7FFE_1234_5678, 0, -1, 52'hABCDE_F000, -1, 1'b0);
    run_req(64'h0000_7FFE_1234_5678, 1, 1, 1, "R6");
    build_chain(64'hFFFF_8012_3456_789A, 2, -1, 52'h3_C000_0000, -1, 1'b0);
    run_req(64'hFFFF_8012_3456_789A, 0, 1, 0, "R7");
    build_chain(64'h0000_0040_1234_5678, 1, -1, 52'h7_7760_0000, -1, 1'b0);
    run_req(64'h0000_0040_1234_5678, 1, 0, 0, "R8");
    build_chain(64'h0000_1111_2222_3333, 0, -1, 52'h5_5555_5000, -1, 1'b1);
    run_req(64'h0000_1111_2222_3333, 0, 0, 0, "R8");
    build_chain(64'h0000_0000_0040_0000, 0, 1, 52'h0, -1, 1'b0);
    run_req(64'h0000_0000_0040_0000, 0, 0, 0, "R5");
    build_chain(64'h0000_6000_0000_0000, 0, 3, 52'h0, -1, 1'b0);
    run_req(64'h0000_6000_0000_0000, 0, 0, 0, "R5");
    run_req(64'h0000_8000_0000_0000, 0, 0, 0, "R2");
    run_req(64'h8000_0000_0000_1000, 0, 0, 0, "R2");
    build_chain(64'h0000_2000_0030_1000, 0, -1, 52'h9_9999_9000, 2, 1'b0);
    run_req(64'h0000_2000_0030_1000, 1, 0, 0, "R10");
    run_req(64'h0000_2000_0030_1000, 0, 1, 0, "R9");
    run_req(64'h0000_2000_0030_1000, 0, 0, 1, "R10");

    for (int i = 0; i < 300; i++) begin
      automatic logic [63:0] va;
      if (($urandom % 10) == 0) va = {$urandom, $urandom};
      else begin
        va[46:0] = {$urandom, $urandom};
        va[63:47] = (($urandom % 2) == 0) ? 17'h0 : 17'h1FFFF;
      end
      populate(va);
      run_req(va, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule